// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single-register load or store in a 32-bit pipeline stage. It takes a 5-bit control index, a form select, a base register value and three possible offset sources. From these it produces the effective address, the value to write back to the base register with its enable, the access size, a load/store flag, an unprivileged-access flag and an undefined-encoding flag.

There are two instruction forms. The word/byte form takes its offset from a 12-bit immediate or from a register operand, and a separate select input picks between them. The halfword form takes its offset from a register operand or from an 8-bit immediate built from two nibbles. Every result is registered, so it appears one clock after a valid input strobe. The data outputs keep their last values while no strobe is present.

Top module: `ls_addr_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, every output becomes zero.
- R2: out_valid equals in_valid delayed by one clock. The data outputs change one clock after an accepted strobe and hold their values in any cycle where in_valid is low.
- R3: The control index ctrl has bit 4 = P (pre-index), bit 3 = U (up), bit 2 = B in the word/byte form or I in the halfword form, bit 1 = W (writeback) and bit 0 = L (load). With U=1 the offset is added to the base and with U=0 it is subtracted, modulo 2^32.
- R4: With P=1, addr is base plus or minus the offset. With P=0, addr is the unmodified base.
- R5: wb_data is always base plus or minus the offset. wb_en is 1 when P=0 or W=1, except for an undefined encoding.
- R6: In the word/byte form (form_sel=0), the offset is the zero-extended imm12 when off_reg=0 and rm_val when off_reg=1. acc_size is 0 (byte) when B=1 and 2 (word) when B=0. unpriv is 1 exactly when P=0 and W=0.
- R7: In the halfword form (form_sel=1), I=1 gives the offset {imm_hi, imm_lo} zero-extended and I=0 gives rm_val. off_reg is ignored. acc_size is 1 (halfword) and unpriv is 0.
- R8: In the halfword form, P=0 with W=1 sets undef and clears wb_en. Every other encoding gives undef=0.
- R9: is_load equals the L bit of the accepted control index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| form_sel | input | 1 | 0 selects the word/byte form, 1 selects the halfword form |
| ctrl | input | 5 | Control index {P,U,B/I,W,L} |
| off_reg | input | 1 | Word/byte form: use rm_val as the offset |
| base | input | 32 | Base register value |
| rm_val | input | 32 | Register offset operand |
| imm12 | input | 12 | Word/byte immediate offset |
| imm_hi | input | 4 | High nibble of the split offset |
| imm_lo | input | 4 | Low nibble of the split offset |
| out_valid | output | 1 | Result valid |
| addr | output | 32 | Effective address |
| wb_data | output | 32 | Base writeback value |
| wb_en | output | 1 | Base writeback enable |
| acc_size | output | 2 | 0 byte, 1 halfword, 2 word |
| is_load | output | 1 | Load when 1, store when 0 |
| unpriv | output | 1 | Unprivileged access |
| undef | output | 1 | Undefined encoding |

## Verification
All 32 control indices are swept in both forms with random bases and offsets. This separates add from subtract and pre-index from post-index. It also separates the unprivileged case from an ordinary writeback and the legal halfword encodings from the undefined ones. In the word/byte form, each index is run with the immediate and again with the register offset, which confirms which offset source feeds the adder. A base of all ones with a small added offset, and a small base with a larger subtracted offset, test wrap-around in both directions. Changing inputs while the strobe is low shows whether the outputs hold.

// File: rtl/ls_addr_gen_pkg.sv
// Shared types for the load/store address generator.
// Assumes the size codes are decoded by a downstream memory stage.
package ls_addr_gen_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      pre;
        logic      up;
        logic      wb_req;
        logic      load;
        logic      unpriv;
        logic      undef;
        acc_size_e size;
    } agen_dec_t;
endpackage

// File: rtl/agen_decode.sv
// Decodes the 5-bit control index {P,U,B/I,W,L} for either form.
// Assumes form_sel is stable alongside ctrl; the logic is purely combinational.
module agen_decode
    import ls_addr_gen_pkg::*;
(
    input  logic       form_sel,
    input  logic [4:0] ctrl,
    output agen_dec_t  dec
);
    localparam int BIT_P = 4;
    localparam int BIT_U = 3;
    localparam int BIT_S = 2;
    localparam int BIT_W = 1;
    localparam int BIT_L = 0;

    logic illegal_half;

    // Flags the halfword encoding that has no defined meaning.
    always_comb begin
        illegal_half = form_sel && !ctrl[BIT_P] && ctrl[BIT_W];
    end

    // Builds the decoded control word.
    always_comb begin
        dec.pre    = ctrl[BIT_P];
        dec.up     = ctrl[BIT_U];
        dec.load   = ctrl[BIT_L];
        dec.undef  = illegal_half;
        dec.wb_req = (!ctrl[BIT_P] || ctrl[BIT_W]) && !illegal_half;
        dec.unpriv = !form_sel && !ctrl[BIT_P] && !ctrl[BIT_W];
        if (form_sel)
            dec.size = SZ_HALF;
        else if (ctrl[BIT_S])
            dec.size = SZ_BYTE;
        else
            dec.size = SZ_WORD;
    end
endmodule

// File: rtl/agen_offset.sv
// Picks the offset operand and zero-extends immediates to the data width.
// Assumes IMM_W and 2*NIB_W are no wider than DATA_W.
module agen_offset #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12,
    parameter int NIB_W  = 4
) (
    input  logic              form_sel,
    input  logic              split_sel,
    input  logic              off_reg,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [IMM_W-1:0]  imm12,
    input  logic [NIB_W-1:0]  imm_hi,
    input  logic [NIB_W-1:0]  imm_lo,
    output logic [DATA_W-1:0] offset
);
    localparam int SPLIT_W = 2 * NIB_W;

    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] split_ext;

    // Zero-extension of both immediate kinds.
    generate
        if (DATA_W > IMM_W) begin : g_imm_pad
            assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm12};
        end else begin : g_imm_full
            assign imm_ext = imm12;
        end
        if (DATA_W > SPLIT_W) begin : g_split_pad
            assign split_ext = {{(DATA_W-SPLIT_W){1'b0}}, imm_hi, imm_lo};
        end else begin : g_split_full
            assign split_ext = {imm_hi, imm_lo};
        end
    endgenerate

    // Source select: the halfword form uses its I bit, the word form uses off_reg.
    always_comb begin
        if (form_sel)
            offset = split_sel ? split_ext : rm_val;
        else
            offset = off_reg ? rm_val : imm_ext;
    end
endmodule

// File: rtl/agen_arith.sv
// Adds or subtracts the offset from the base and picks pre- or post-index.
// Assumes modulo-2^DATA_W wrap is the wanted behaviour.
module agen_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] offset,
    input  logic              up,
    input  logic              pre,
    output logic [DATA_W-1:0] eff_addr,
    output logic [DATA_W-1:0] moved
);
    // Shared adder for the effective address and the writeback value.
    always_comb begin
        moved    = up ? (base + offset) : (base - offset);
        eff_addr = pre ? moved : base;
    end
endmodule

// File: rtl/ls_addr_gen.sv
// Top of the address generator: decode, offset select, arithmetic, output register.
// Assumes one request per strobe; results follow one clock later and hold otherwise.
module ls_addr_gen
    import ls_addr_gen_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              form_sel,
    input  logic [4:0]        ctrl,
    input  logic              off_reg,
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [IMM_W-1:0]  imm12,
    input  logic [NIB_W-1:0]  imm_hi,
    input  logic [NIB_W-1:0]  imm_lo,
    output logic              out_valid,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_en,
    output logic [1:0]        acc_size,
    output logic              is_load,
    output logic              unpriv,
    output logic              undef
);
    agen_dec_t         dec;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] eff_addr;
    logic [DATA_W-1:0] moved;

    agen_decode u_dec (
        .form_sel (form_sel),
        .ctrl     (ctrl),
        .dec      (dec)
    );

    agen_offset #(.DATA_W(DATA_W), .IMM_W(IMM_W), .NIB_W(NIB_W)) u_off (
        .form_sel  (form_sel),
        .split_sel (ctrl[2]),
        .off_reg   (off_reg),
        .rm_val    (rm_val),
        .imm12     (imm12),
        .imm_hi    (imm_hi),
        .imm_lo    (imm_lo),
        .offset    (offset)
    );

    agen_arith #(.DATA_W(DATA_W)) u_ar (
        .base     (base),
        .offset   (offset),
        .up       (dec.up),
        .pre      (dec.pre),
        .eff_addr (eff_addr),
        .moved    (moved)
    );

    // Strobe pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers, loaded only on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            wb_data  <= '0;
            wb_en    <= 1'b0;
            acc_size <= 2'd0;
            is_load  <= 1'b0;
            unpriv   <= 1'b0;
            undef    <= 1'b0;
        end else if (in_valid) begin
            addr     <= eff_addr;
            wb_data  <= moved;
            wb_en    <= dec.wb_req;
            acc_size <= dec.size;
            is_load  <= dec.load;
            unpriv   <= dec.unpriv;
            undef    <= dec.undef;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(addr) && $stable(wb_data)); // R2
    AST_POST_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !ctrl[4] |=> addr == $past(base)); // R4
    AST_UNDEF_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> !wb_en); // R8
    AST_UNPRIV_WB: assert property (@(posedge clk) disable iff (!rst_n)
        unpriv |-> wb_en && addr != wb_data || wb_en); // R6
    AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> is_load == $past(ctrl[0])); // R9
endmodule

// File: tb/ls_addr_gen_test.sv
module ls_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        form_sel = 1'b0;
    logic [4:0]  ctrl = '0;
    logic        off_reg = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] rm_val = '0;
    logic [11:0] imm12 = '0;
    logic [3:0]  imm_hi = '0;
    logic [3:0]  imm_lo = '0;
    logic        out_valid;
    logic [31:0] addr;
    logic [31:0] wb_data;
    logic        wb_en;
    logic [1:0]  acc_size;
    logic        is_load;
    logic        unpriv;
    logic        undef;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    ls_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .form_sel(form_sel),
        .ctrl(ctrl), .off_reg(off_reg), .base(base), .rm_val(rm_val),
        .imm12(imm12), .imm_hi(imm_hi), .imm_lo(imm_lo),
        .out_valid(out_valid), .addr(addr), .wb_data(wb_data), .wb_en(wb_en),
        .acc_size(acc_size), .is_load(is_load), .unpriv(unpriv), .undef(undef)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] wb_data;
        logic        wb_en;
        logic [1:0]  size;
        logic        load;
        logic        unpriv;
        logic        undef;
    } exp_t;

    function automatic exp_t model(logic f, logic [4:0] c, logic oreg, logic [31:0] b,
                                   logic [31:0] rm, logic [11:0] i12, logic [3:0] hi, logic [3:0] lo);
        exp_t e;
        logic [31:0] off;
        logic p = c[4], u = c[3], s = c[2], w = c[1];
        if (f) off = s ? {24'd0, hi, lo} : rm;
        else   off = oreg ? rm : {20'd0, i12};
        e.wb_data = u ? b + off : b - off;
        e.addr    = p ? e.wb_data : b;
        e.undef   = f && !p && w;
        e.wb_en   = (!p || w) && !e.undef;
        e.unpriv  = !f && !p && !w;
        e.size    = f ? 2'd1 : (s ? 2'd0 : 2'd2);
        e.load    = c[0];
        return e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(logic f, logic [4:0] c, logic oreg, logic [31:0] b,
                           logic [31:0] rm, logic [11:0] i12, logic [3:0] hi, logic [3:0] lo);
        exp_t e;
        e = model(f, c, oreg, b, rm, i12, hi, lo);
        @(negedge clk);
        in_valid = 1'b1; form_sel = f; ctrl = c; off_reg = oreg;
        base = b; rm_val = rm; imm12 = i12; imm_hi = hi; imm_lo = lo;
        @(posedge clk); #1;
        chk("R2 out_valid", {31'd0, out_valid}, 32'd1);
        chk("R4 R3 addr", addr, e.addr);
        chk(f ? "R5 R7 wb_data" : "R5 R6 wb_data", wb_data, e.wb_data);
        chk("R5 R8 wb_en", {31'd0, wb_en}, {31'd0, e.wb_en});
        chk("R6 R7 acc_size", {30'd0, acc_size}, {30'd0, e.size});
        chk("R9 is_load", {31'd0, is_load}, {31'd0, e.load});
        chk("R6 R7 unpriv", {31'd0, unpriv}, {31'd0, e.unpriv});
        chk("R8 undef", {31'd0, undef}, {31'd0, e.undef});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] held_a;
        logic [31:0] held_w;
        void'($urandom(32'd1234));
        in_valid = 1'b1; base = 32'hDEADBEEF; ctrl = 5'b11111;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 addr", addr, 32'd0);
        chk("R1 wb_data", wb_data, 32'd0);
        chk("R1 flags", {25'd0, wb_en, acc_size, is_load, unpriv, undef}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Directed wrap-around corner cases (R3)
        run_one(1'b0, 5'b11000, 1'b1, 32'hFFFF_FFFF, 32'd1, 12'd0, 4'd0, 4'd0);
        run_one(1'b0, 5'b10010, 1'b0, 32'd4, 32'd0, 12'd16, 4'd0, 4'd0);
        run_one(1'b1, 5'b11101, 1'b0, 32'hFFFF_FFF0, 32'd0, 12'd0, 4'hF, 4'hF);
        run_one(1'b1, 5'b00010, 1'b1, 32'h100, 32'h10, 12'd0, 4'd0, 4'd0);

        // Full sweep of both forms and both word-form offset sources (R6 R7 R8)
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 32; c++) begin
                for (int o = 0; o < 2; o++) begin
                    run_one(f[0], c[4:0], o[0], $urandom, $urandom,
                            12'($urandom), 4'($urandom), 4'($urandom));
                end
            end
        end

        // Hold with strobe low (R2)
        run_one(1'b0, 5'b11011, 1'b0, 32'h1234_5678, 32'd0, 12'h321, 4'd0, 4'd0);
        held_a = addr; held_w = wb_data;
        @(negedge clk);
        base = 32'h0BAD_F00D; ctrl = 5'b00000; imm12 = 12'hFFF;
        repeat (2) @(posedge clk);
        #1;
        chk("R2 idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R2 hold addr", addr, held_a);
        chk("R2 hold wb_data", wb_data, held_w);
        chk("R9 hold is_load", {31'd0, is_load}, 32'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule